// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block collects up to fifteen interrupt request lines, numbered 1 to 15, and presents one processor with a 4-bit interrupt level. Each line is recorded when its input rises. A line counts as active when it is pending or forced, and also enabled in the mask. A per-line group register puts some lines in a high-priority group. If any line in that group is active, only that group is considered when the output level is chosen. Within the chosen group the highest-numbered active line wins. The processor retires a line by presenting its number on the acknowledge pins. Software can also clear lines through the register bus.

Software uses a 32-bit register bus made of a write strobe, a read strobe, a byte address and data. The bus has no back-pressure: every access is taken in the cycle it is presented. Read data appears one cycle after the read strobe and then holds until the next read. The mask, force and extra-bits registers are repeated once per processor slot, and the number of slots is a parameter. Slot 0 drives the output. A line can be set to broadcast mode. A rising edge on a broadcast line sets that line in the force register of every slot and leaves its pending bit alone.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq_level` is 0 and `bus_rdata` is 0.
- R2: A rising edge on `irq_req[n]` (n from 1 to 15) with broadcast bit n clear sets pending bit n, which reads back at offset 0x04. A line held high sets it only once.
- R3: The active set is (pending OR slot-0 force) AND slot-0 mask. `irq_level` is the number of the highest active line in the chosen group, or 0 when no line is active.
- R4: Lines whose group bit is 1 (group register at 0x00) form the high group. When any high-group line is active, `irq_level` names a high-group line, even if a higher-numbered low-group line is also active.
- R5: Writing the clear register (0x0C) clears the written bits in both pending and the slot-0 force register. The clear register reads as zero.
- R6: An acknowledge with number n clears bit n of pending and of the slot-0 force register. Number 0 has no effect.
- R7: A write to the force register of slot c (0x80 + 4c) sets the lines given in data[15:1] and then clears the lines given in data[31:17]. A write to 0x08 replaces the slot-0 force value, and 0x08 reads the slot-0 force value.
- R8: The broadcast register is at 0x14. A rising edge on a line whose broadcast bit is set sets that bit in the force register of every slot and leaves pending unchanged.
- R9: Line 0 does not exist. Bit 0 is stored as zero in the group, force, broadcast and mask registers, and an edge on `irq_req[0]` has no effect. Writes to pending (0x04) and to the status word (0x10) are ignored, and the status word reads zero.
- R10: The extra-bits register of slot c (0xC0 + 4c) keeps only data[3:0].
- R11: Unmapped addresses read zero and ignore writes. These include offsets not aligned to a word, the unused words between 0x18 and 0x3C, and slot words whose slot number is at or above `NCPU`.
- R12: If a new rising edge on a line arrives in the same cycle as an acknowledge or clear of that line, the edge wins and the line stays pending.
- R13: `bus_rdata` takes the selected value on the clock edge at which `bus_rd` is high, and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 16 | Request lines; bit n is line n, bit 0 unused |
| ack_valid | input | 1 | Acknowledge strobe from the processor |
| ack_num | input | 4 | Number of the line being acknowledged |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_level | output | 4 | Interrupt level presented to the processor |

## Verification
The case that needs care is a line's new rising edge landing in the same cycle as its removal. The removal can come from an acknowledge or from a clear-register write. The bench first sets the line pending and lets the request input fall. It then drives the rising input and the removal between the same pair of clock edges. It reads pending afterwards and expects the line still set, then sends a lone acknowledge and expects the bit to go.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_GROUP,
    SEL_PEND,
    SEL_FALIAS,
    SEL_CLEAR,
    SEL_STATUS,
    SEL_BCAST,
    SEL_MASK,
    SEL_FORCE,
    SEL_EXT
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e   sel;
    logic [3:0] slot;
  } reg_dec_t;

  // Byte address: [7:6] bank, [5:2] word/slot, [1:0] must be zero.
  function automatic reg_dec_t decode_addr(input logic [7:0] a, input int unsigned ncpu);
    reg_dec_t d;
    d.sel  = SEL_NONE;
    d.slot = a[5:2];
    if (a[1:0] == 2'b00) begin
      case (a[7:6])
        2'b00: begin
          case (a[5:2])
            4'd0:    d.sel = SEL_GROUP;
            4'd1:    d.sel = SEL_PEND;
            4'd2:    d.sel = SEL_FALIAS;
            4'd3:    d.sel = SEL_CLEAR;
            4'd4:    d.sel = SEL_STATUS;
            4'd5:    d.sel = SEL_BCAST;
            default: d.sel = SEL_NONE;
          endcase
        end
        2'b01:   if (32'(a[5:2]) < ncpu) d.sel = SEL_MASK;
        2'b10:   if (32'(a[5:2]) < ncpu) d.sel = SEL_FORCE;
        default: if (32'(a[5:2]) < ncpu) d.sel = SEL_EXT;
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/ipc_edge.sv
module ipc_edge #(
  parameter int unsigned LINES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req,
  output logic [LINES-1:0] rise
);
  localparam logic [LINES-1:0] LINE_M = {{(LINES-1){1'b1}}, 1'b0};

  logic [LINES-1:0] req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req;
  end

  assign rise = req & ~req_q & LINE_M;
endmodule

// File: rtl/ipc_regs.sv
module ipc_regs
  import ipc_pkg::*;
#(
  parameter int unsigned NCPU  = 4,
  parameter int unsigned LINES = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [7:0]               bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic [LINES-1:0]         rise,
  input  logic                     ack_valid,
  input  logic [$clog2(LINES)-1:0] ack_num,
  output logic [LINES-1:0]         pend_o,
  output logic [LINES-1:0]         frc0_o,
  output logic [LINES-1:0]         msk0_o,
  output logic [LINES-1:0]         grp_o,
  output logic [LINES-1:0]         bcast_o
);
  localparam logic [LINES-1:0] LINE_M = {{(LINES-1){1'b1}}, 1'b0};
  localparam int unsigned CLR_LSB = 16;

  reg_dec_t dec;
  assign dec = decode_addr(bus_addr, NCPU);

  logic wr_group, wr_clear, wr_bcast, wr_alias;
  assign wr_group = bus_wr && (dec.sel == SEL_GROUP);
  assign wr_clear = bus_wr && (dec.sel == SEL_CLEAR);
  assign wr_bcast = bus_wr && (dec.sel == SEL_BCAST);
  assign wr_alias = bus_wr && (dec.sel == SEL_FALIAS);

  logic [LINES-1:0] wd_set, wd_clr;
  assign wd_set = bus_wdata[LINES-1:0] & LINE_M;
  assign wd_clr = bus_wdata[CLR_LSB +: LINES] & LINE_M;

  logic [LINES-1:0] pend_q, grp_q, bcast_q;
  logic [LINES-1:0] msk_q [NCPU];
  logic [LINES-1:0] frc_q [NCPU];
  logic [3:0]       ext_q [NCPU];

  // Removal vector for slot 0 and pending: acknowledge and clear register
  logic [LINES-1:0] ack_vec, clr_vec, set_pend, set_frc;
  assign ack_vec  = ack_valid ? ((LINES'(1) << ack_num) & LINE_M) : '0;
  assign clr_vec  = ack_vec | (wr_clear ? wd_set : '0);
  assign set_pend = rise & ~bcast_q;
  assign set_frc  = rise & bcast_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      grp_q   <= '0;
      bcast_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_vec) | set_pend;   // new edge wins over removal
      if (wr_group) grp_q   <= wd_set;
      if (wr_bcast) bcast_q <= wd_set;
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_slot
    localparam bit IS0 = (c == 0);
    logic hit_msk, hit_frc, hit_ext;
    logic [LINES-1:0] frc_nxt;

    assign hit_msk = bus_wr && (dec.sel == SEL_MASK)  && (dec.slot == 4'(c));
    assign hit_frc = bus_wr && (dec.sel == SEL_FORCE) && (dec.slot == 4'(c));
    assign hit_ext = bus_wr && (dec.sel == SEL_EXT)   && (dec.slot == 4'(c));

    always_comb begin
      frc_nxt = frc_q[c];
      if (hit_frc)          frc_nxt = (frc_nxt | wd_set) & ~wd_clr;
      if (IS0 && wr_alias)  frc_nxt = wd_set;
      frc_nxt = frc_nxt & ~(IS0 ? clr_vec : '0);
      frc_nxt = frc_nxt | set_frc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        msk_q[c] <= '0;
        frc_q[c] <= '0;
        ext_q[c] <= '0;
      end else begin
        frc_q[c] <= frc_nxt;
        if (hit_msk) msk_q[c] <= wd_set;
        if (hit_ext) ext_q[c] <= bus_wdata[3:0];
      end
    end
  end

  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    case (dec.sel)
      SEL_GROUP:  rd_val = 32'(grp_q);
      SEL_PEND:   rd_val = 32'(pend_q);
      SEL_FALIAS: rd_val = 32'(frc_q[0]);
      SEL_BCAST:  rd_val = 32'(bcast_q);
      SEL_MASK:   for (int c = 0; c < NCPU; c++) if (dec.slot == 4'(c)) rd_val = 32'(msk_q[c]);
      SEL_FORCE:  for (int c = 0; c < NCPU; c++) if (dec.slot == 4'(c)) rd_val = 32'(frc_q[c]);
      SEL_EXT:    for (int c = 0; c < NCPU; c++) if (dec.slot == 4'(c)) rd_val = 32'(ext_q[c]);
      default:    rd_val = '0;
    endcase
  end

  logic [31:0] rdata_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_val;
  end

  assign bus_rdata = rdata_q;
  assign pend_o    = pend_q;
  assign frc0_o    = frc_q[0];
  assign msk0_o    = msk_q[0];
  assign grp_o     = grp_q;
  assign bcast_o   = bcast_q;
endmodule

// File: rtl/ipc_prio.sv
module ipc_prio #(
  parameter int unsigned LINES = 16
) (
  input  logic [LINES-1:0]         pend,
  input  logic [LINES-1:0]         frc,
  input  logic [LINES-1:0]         msk,
  input  logic [LINES-1:0]         grp,
  output logic [$clog2(LINES)-1:0] level
);
  localparam int unsigned LVL_W = $clog2(LINES);

  logic [LINES-1:0] act, hi, lo, win;
  assign act = (pend | frc) & msk;
  assign hi  = act & grp;
  assign lo  = act & ~grp;
  assign win = (|hi) ? hi : lo;

  always_comb begin
    level = '0;
    for (int i = 1; i < LINES; i++) begin
      if (win[i]) level = LVL_W'(i);
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int unsigned NCPU  = 4,
  parameter int unsigned LINES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_req,
  input  logic        ack_valid,
  input  logic [3:0]  ack_num,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [3:0]  irq_level
);
  logic [LINES-1:0] rise_vec, pend_q, frc0_q, msk0_q, grp_q, bcast_q;

  ipc_edge #(.LINES(LINES)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (irq_req[LINES-1:0]),
    .rise (rise_vec)
  );

  ipc_regs #(.NCPU(NCPU), .LINES(LINES)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .rise     (rise_vec),
    .ack_valid(ack_valid),
    .ack_num  (ack_num),
    .pend_o   (pend_q),
    .frc0_o   (frc0_q),
    .msk0_o   (msk0_q),
    .grp_o    (grp_q),
    .bcast_o  (bcast_q)
  );

  ipc_prio #(.LINES(LINES)) u_prio (
    .pend (pend_q),
    .frc  (frc0_q),
    .msk  (msk0_q),
    .grp  (grp_q),
    .level(irq_level)
  );
endmodule

// File: rtl/ipc_chk.sv
module ipc_chk #(
  parameter int unsigned LINES = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack_valid,
  input logic [3:0]       ack_num,
  input logic             bus_rd,
  input logic [7:0]       bus_addr,
  input logic [31:0]      bus_rdata,
  input logic [3:0]       irq_level,
  input logic [LINES-1:0] rise_vec,
  input logic [LINES-1:0] pend_q,
  input logic [LINES-1:0] frc0_q,
  input logic [LINES-1:0] msk0_q,
  input logic [LINES-1:0] grp_q,
  input logic [LINES-1:0] bcast_q
);
  logic [LINES-1:0] act;
  assign act = (pend_q | frc0_q) & msk0_q;

  // R3
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == '0) |-> (irq_level == '0));

  // R3
  level_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0) |-> act[irq_level]);

  // R4
  high_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(act & grp_q)) |-> grp_q[irq_level]);

  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !rise_vec[ack_num]) |=> !pend_q[$past(ack_num)]);

  // R12
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rise_vec & ~bcast_q)) |=> ((pend_q & $past(rise_vec & ~bcast_q)) == $past(rise_vec & ~bcast_q)));

  // R9
  no_line0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_q[0] || frc0_q[0] || msk0_q[0] || grp_q[0] || bcast_q[0]));

  // R5
  clear_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 8'h0C) |=> (bus_rdata == 32'h0));

  // R13
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind irq_prio_ctrl ipc_chk #(.LINES(LINES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ack_valid(ack_valid),
  .ack_num  (ack_num),
  .bus_rd   (bus_rd),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .irq_level(irq_level),
  .rise_vec (rise_vec),
  .pend_q   (pend_q),
  .frc0_q   (frc0_q),
  .msk0_q   (msk0_q),
  .grp_q    (grp_q),
  .bcast_q  (bcast_q)
);

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_req = '0;
  logic        ack_valid = 1'b0;
  logic [3:0]  ack_num = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_level;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  irq_prio_ctrl #(.NCPU(4), .LINES(16)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .ack_valid(ack_valid), .ack_num(ack_num),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_level(irq_level)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(req, bus_rdata, exp);
  endtask

  task automatic lvl_chk(input string req, input logic [3:0] exp);
    @(negedge clk);
    chk(req, 32'(irq_level), 32'(exp));
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    irq_req[n] = 1'b1;
    @(negedge clk);
    irq_req[n] = 1'b0;
  endtask

  task automatic ack(input logic [3:0] n);
    @(negedge clk);
    ack_valid = 1'b1; ack_num = n;
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic wipe();
    wr(8'h0C, 32'h0000_FFFF);
    for (int c = 0; c < 4; c++) wr(8'h80 + 8'(4 * c), 32'hFFFF_0000);
    wr(8'h40, 32'h0);
    wr(8'h00, 32'h0);
    wr(8'h14, 32'h0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 level", 32'(irq_level), 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    rd_chk("R1 group", 8'h00, 32'h0);
    rd_chk("R1 pending", 8'h04, 32'h0);
    rd_chk("R1 mask0", 8'h40, 32'h0);
    rd_chk("R1 force0", 8'h80, 32'h0);
  endtask

  task automatic t_pending();
    wipe();
    pulse(5);
    rd_chk("R2 edge sets pending", 8'h04, 32'h0020);
    @(negedge clk); irq_req[7] = 1'b1;
    repeat (3) @(negedge clk);
    wr(8'h0C, 32'h0080);
    rd_chk("R2 held line sets once", 8'h04, 32'h0020);
    @(negedge clk); irq_req[7] = 1'b0;
    pulse(0);
    rd_chk("R9 line0 edge ignored", 8'h04, 32'h0020);
  endtask

  task automatic t_output();
    wr(8'h40, 32'hFFFE);
    lvl_chk("R3 single line", 4'd5);
    pulse(9);
    lvl_chk("R3 highest wins", 4'd9);
    wr(8'h40, 32'h0020);
    lvl_chk("R3 mask hides 9", 4'd5);
    wr(8'h40, 32'h0);
    lvl_chk("R3 all masked", 4'd0);
    wr(8'h40, 32'hFFFE);
    wr(8'h08, 32'h0800);
    lvl_chk("R3 force0 drives", 4'd11);
    wr(8'h08, 32'h0);
  endtask

  task automatic t_groups();
    wr(8'h00, 32'h0020);
    lvl_chk("R4 high group beats higher low line", 4'd5);
    wr(8'h00, 32'h0220);
    lvl_chk("R4 highest in high group", 4'd9);
    wr(8'h00, 32'h0800);
    lvl_chk("R4 inactive high group falls to low", 4'd9);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_clear();
    wr(8'h0C, 32'h0220);
    rd_chk("R5 clear pending", 8'h04, 32'h0);
    wr(8'h08, 32'h0008);
    rd_chk("R7 alias write", 8'h08, 32'h0008);
    wr(8'h0C, 32'h0008);
    rd_chk("R5 clear force0", 8'h08, 32'h0);
    rd_chk("R5 clear reads zero", 8'h0C, 32'h0);
  endtask

  task automatic t_ack();
    pulse(3);
    lvl_chk("R6 before ack", 4'd3);
    ack(4'd3);
    rd_chk("R6 ack clears pending", 8'h04, 32'h0);
    wr(8'h80, 32'h0010);
    ack(4'd4);
    rd_chk("R6 ack clears force0", 8'h80, 32'h0);
    pulse(2);
    ack(4'd0);
    rd_chk("R6 ack 0 no effect", 8'h04, 32'h0004);
    ack(4'd2);
    lvl_chk("R6 level after ack", 4'd0);
  endtask

  task automatic t_force();
    wr(8'h84, 32'h0000_0006);
    rd_chk("R7 slot1 set", 8'h84, 32'h0006);
    wr(8'h84, 32'h0004_0008);
    rd_chk("R7 slot1 set and clear", 8'h84, 32'h000A);
    wr(8'h08, 32'h0000_1234);
    rd_chk("R7 alias replaces", 8'h80, 32'h1234);
    wr(8'h80, 32'h0004_0000);
    rd_chk("R7 slot0 clear field", 8'h08, 32'h1230);
  endtask

  task automatic t_bcast();
    wipe();
    wr(8'h14, 32'h0400);
    pulse(10);
    rd_chk("R8 pending untouched", 8'h04, 32'h0);
    for (int c = 0; c < 4; c++) rd_chk("R8 force slot", 8'h80 + 8'(4 * c), 32'h0400);
    rd_chk("R8 broadcast reg", 8'h14, 32'h0400);
    wipe();
  endtask

  task automatic t_bit0();
    wr(8'h00, 32'hFFFF);
    rd_chk("R9 group bit0", 8'h00, 32'hFFFE);
    wr(8'h00, 32'h0);
    wr(8'h14, 32'h0001);
    rd_chk("R9 broadcast bit0", 8'h14, 32'h0);
    wr(8'h40, 32'h0001);
    rd_chk("R9 mask bit0", 8'h40, 32'h0);
    wr(8'h08, 32'h0001);
    rd_chk("R9 force bit0", 8'h08, 32'h0);
    pulse(4);
    wr(8'h04, 32'hFFFF);
    rd_chk("R9 pending write ignored", 8'h04, 32'h0010);
    wr(8'h10, 32'hFFFF);
    rd_chk("R9 status reads zero", 8'h10, 32'h0);
    wr(8'h0C, 32'hFFFF);
  endtask

  task automatic t_ext();
    wr(8'hC4, 32'hFFFF_FFFF);
    rd_chk("R10 ext low bits", 8'hC4, 32'h000F);
    rd_chk("R10 ext other slot", 8'hC0, 32'h0);
  endtask

  task automatic t_unmapped();
    wr(8'h20, 32'hFFFF);
    rd_chk("R11 gap word", 8'h20, 32'h0);
    wr(8'h90, 32'hFFFF);
    rd_chk("R11 force slot beyond NCPU", 8'h90, 32'h0);
    rd_chk("R11 mask slot beyond NCPU", 8'h50, 32'h0);
    wr(8'h41, 32'hFFFF);
    rd_chk("R11 unaligned write ignored", 8'h40, 32'h0);
    rd_chk("R11 unaligned read zero", 8'h05, 32'h0);
  endtask

  task automatic t_race();
    wipe();
    pulse(6);
    rd_chk("R12 setup", 8'h04, 32'h0040);
    @(negedge clk);
    irq_req[6] = 1'b1; ack_valid = 1'b1; ack_num = 4'd6;
    @(negedge clk);
    irq_req[6] = 1'b0; ack_valid = 1'b0;
    rd_chk("R12 edge beats ack", 8'h04, 32'h0040);
    @(negedge clk);
    irq_req[6] = 1'b1; bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h0040;
    @(negedge clk);
    irq_req[6] = 1'b0; bus_wr = 1'b0;
    rd_chk("R12 edge beats clear", 8'h04, 32'h0040);
    ack(4'd6);
    rd_chk("R12 lone ack clears", 8'h04, 32'h0);
  endtask

  task automatic t_rdata();
    rd_chk("R13 read", 8'h04, 32'h0);
    pulse(2);
    repeat (2) @(negedge clk);
    chk("R13 hold without read", bus_rdata, 32'h0);
    rd_chk("R13 fresh read", 8'h04, 32'h0004);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_pending();
    t_output();
    t_groups();
    t_clear();
    t_ack();
    t_force();
    t_bcast();
    t_bit0();
    t_ext();
    t_unmapped();
    t_race();
    t_rdata();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule